// File: doc/BRIEF.md
# Lane Mux Control Register Target

This block is the serial-bus target that configures a four-lane high-speed mux and redriver. A host on an I2C bus writes a small set of control registers at the block's 7-bit address. The block then drives parallel control lines into the analog datapath: an enable per connector-side lane, a DisplayPort-or-USB select per lane, an orientation (flip) flag, eight 4-bit equalizer codes and a 4-bit output-swing/gain code. A second copy of the registers feeds those lines. It loads only at the bus STOP condition, so a multi-byte configuration reaches the datapath in a single step.

The first byte after the address byte sets a register index. Further bytes write at that index and advance it. A read, normally started with a repeated START after the index byte, returns the register at the index and advances it. When the equalizer or gain override bits are clear, the matching outputs come from the strap inputs rather than from the registers.

Top module: `lmx_ctrl`

## Requirements
- R1: The block pulls SDA low in the acknowledge slot only for an address byte whose upper seven bits equal the parameter `TGT_ADDR` (default 0x44). Any other address is not acknowledged, and the bytes that follow it change no register.
- R2: In a write transfer, the first data byte loads the register index. Each later byte writes the register at the index, and the index then increments by one.
- R3: In a read transfer, each byte returns the register at the current index, and the index then increments. Indices other than 0x0A, 0x0C, 0x10, 0x11, 0x20 and 0x21 read as 0x00 and discard writes, but still advance the index.
- R4: Reset clears every register to 0x00. With all registers at zero, every lane is disabled, no lane selects DP, flip is 0 and the role is 0. The equalizer outputs repeat `strap_eq_i` in all eight fields, and the gain output equals `strap_vod_i`.
- R5: The control outputs change only when a STOP condition completes a transfer. Bytes already written in an unfinished transfer leave them unchanged.
- R6: In register 0x0A, bits 1:0 select the lane mode: 0 = all lanes off; 1 = USB only, on one lane pair; 2 = all four lanes DP; 3 = one pair DP and the other pair USB. `lane_en_o` bit n enables lane n, and `lane_dp_o` bit n set means lane n carries DP.
- R7: Bit 2 of register 0x0A is the flip flag and drives `flip_o`. With flip clear, the USB pair is lanes 1:0 (`lane_en_o`=0011 in mode 1, `lane_dp_o`=1100 in mode 3). With flip set, the USB pair is lanes 3:2 (1100 in mode 1, `lane_dp_o`=0011 in mode 3). Mode 2 does not depend on flip.
- R8: Bit 4 of register 0x0A is the equalizer override. While it is set, `eq_code_o` is {reg 0x21, reg 0x20, reg 0x11, reg 0x10}. In each byte, the high nibble is the TX code and the low nibble is the RX code. While it is clear, every 4-bit field equals `strap_eq_i`.
- R9: In register 0x0C, bits 1:0 drive `role_o` (0 USB+DP source, 1 USB+DP sink, 2 USB+custom source, 3 USB+custom sink). Bit 6 selects whether `vod_gain_o` takes bits 5:2 (bit 6 = 1) or `strap_vod_i` (bit 6 = 0). The field's upper two bits are the CFG1 strap code and its lower two bits are the CFG0 strap code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen at the pad |
| sda_i | input | 1 | I2C data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| strap_eq_i | input | 4 | Equalizer code from straps, used without override |
| strap_vod_i | input | 4 | Gain code from straps {CFG1,CFG0}, used without override |
| lane_en_o | output | 4 | Per-lane enable |
| lane_dp_o | output | 4 | Per-lane DP select (0 = USB) |
| flip_o | output | 1 | Orientation flip flag |
| eq_code_o | output | 32 | Eight 4-bit equalizer codes |
| vod_gain_o | output | 4 | Output swing / DC gain code |
| role_o | output | 2 | Data-role select |

## Verification
The protocol assertions assume that the bus lines are clean and slow compared with `clk`. They also assume that SDA moves while SCL is high only to form START or STOP, and never in the same synchronized cycle as an SCL edge. The stimulus meets these assumptions by holding each SCL phase for ten clocks and moving SDA three clocks after SCL has fallen. It models SDA as a wired-AND of the host drive and `sda_oe_o`, so acknowledge and read bits are seen as a real pull-down.

// File: rtl/lmx_pkg.sv
package lmx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACK_A, ST_WDATA, ST_ACK_W, ST_RDATA, ST_RACK
  } i2c_st_e;

  localparam int NSLOT  = 6;
  localparam int SLOT_W = $clog2(NSLOT);
  localparam int LANES  = 4;
  localparam int EQ_W   = 4;

  localparam logic [SLOT_W-1:0] SL_MODE = 3'd0;
  localparam logic [SLOT_W-1:0] SL_GAIN = 3'd1;
  localparam logic [SLOT_W-1:0] SL_UP1  = 3'd2;
  localparam logic [SLOT_W-1:0] SL_UP2  = 3'd3;
  localparam logic [SLOT_W-1:0] SL_DN1  = 3'd4;
  localparam logic [SLOT_W-1:0] SL_DN2  = 3'd5;

  typedef enum logic [1:0] {
    MODE_OFF, MODE_USB, MODE_DP4, MODE_DP2_USB
  } lane_mode_e;

  // {hit, slot} for a bus register index
  function automatic logic [SLOT_W:0] slot_of(input logic [7:0] idx);
    case (idx)
      8'h0A:   return {1'b1, SL_MODE};
      8'h0C:   return {1'b1, SL_GAIN};
      8'h10:   return {1'b1, SL_UP1};
      8'h11:   return {1'b1, SL_UP2};
      8'h20:   return {1'b1, SL_DN1};
      8'h21:   return {1'b1, SL_DN2};
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/lmx_i2c_tgt.sv
module lmx_i2c_tgt
  import lmx_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR    = 7'h44,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  output logic       wr_en_o,
  output logic [7:0] idx_o,
  output logic [7:0] wr_data_o,
  input  logic [7:0] rd_data_i,
  output logic       stop_o
);
  logic [SYNC_STAGES-1:0] scl_sync_q, sda_sync_q;
  logic scl_prev_q, sda_prev_q, scl_s, sda_s;
  logic scl_rise, scl_fall, start_det, stop_det;

  i2c_st_e    state_q, state_d;
  logic [3:0] cnt_q, cnt_d;
  logic [7:0] shreg_q, shreg_d, tx_q, tx_d, idx_q, idx_d;
  logic       rw_q, rw_d, pend_q, pend_d;

  assign scl_s     = scl_sync_q[SYNC_STAGES-1];
  assign sda_s     = sda_sync_q[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_prev_q;
  assign scl_fall  = ~scl_s & scl_prev_q;
  assign start_det = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
  assign stop_det  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    shreg_d = shreg_q;
    tx_d    = tx_q;
    idx_d   = idx_q;
    rw_d    = rw_q;
    pend_d  = pend_q;
    wr_en_o = 1'b0;
    if (start_det) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_ADDR: begin
          if (scl_rise) begin
            shreg_d = {shreg_q[6:0], sda_s};
            cnt_d   = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            if (shreg_q[7:1] == TGT_ADDR) begin
              state_d = ST_ACK_A;
              rw_d    = shreg_q[0];
              pend_d  = ~shreg_q[0];
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        ST_ACK_A: if (scl_fall) begin
          cnt_d = '0;
          if (rw_q) begin
            state_d = ST_RDATA;
            tx_d    = rd_data_i;
            idx_d   = idx_q + 8'd1;
          end else begin
            state_d = ST_WDATA;
          end
        end
        ST_WDATA: begin
          if (scl_rise) begin
            shreg_d = {shreg_q[6:0], sda_s};
            cnt_d   = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            state_d = ST_ACK_W;
            if (pend_q) begin
              idx_d  = shreg_q;
              pend_d = 1'b0;
            end else begin
              wr_en_o = 1'b1;
              idx_d   = idx_q + 8'd1;
            end
          end
        end
        ST_ACK_W: if (scl_fall) begin
          state_d = ST_WDATA;
          cnt_d   = '0;
        end
        ST_RDATA: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall) begin
            if (cnt_q == 4'd8) state_d = ST_RACK;
            else               tx_d = {tx_q[6:0], 1'b0};
          end
        end
        ST_RACK: begin
          if (scl_rise && sda_s) begin
            state_d = ST_IDLE;
          end else if (scl_fall) begin
            state_d = ST_RDATA;
            cnt_d   = '0;
            tx_d    = rd_data_i;
            idx_d   = idx_q + 8'd1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync_q <= '1;
      sda_sync_q <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      shreg_q    <= '0;
      tx_q       <= '0;
      idx_q      <= '0;
      rw_q       <= 1'b0;
      pend_q     <= 1'b0;
    end else begin
      scl_sync_q <= {scl_sync_q[SYNC_STAGES-2:0], scl_i};
      sda_sync_q <= {sda_sync_q[SYNC_STAGES-2:0], sda_i};
      scl_prev_q <= scl_s;
      sda_prev_q <= sda_s;
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      shreg_q    <= shreg_d;
      tx_q       <= tx_d;
      idx_q      <= idx_d;
      rw_q       <= rw_d;
      pend_q     <= pend_d;
    end
  end

  assign sda_oe_o  = (state_q == ST_ACK_A) | (state_q == ST_ACK_W) |
                     ((state_q == ST_RDATA) & ~tx_q[7]);
  assign idx_o     = idx_q;
  assign wr_data_o = shreg_q;
  assign stop_o    = stop_det;

  // R1: acknowledge phase is entered only after our own address was shifted in
  p_ack_own_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_ACK_A) |-> (shreg_q[7:1] == TGT_ADDR));
  // R2: each data byte produces exactly one single-cycle write strobe
  p_wr_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> !wr_en_o);
endmodule

// File: rtl/lmx_regs.sv
module lmx_regs
  import lmx_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en_i,
  input  logic [7:0]            idx_i,
  input  logic [7:0]            wr_data_i,
  input  logic                  commit_i,
  output logic [7:0]            rd_data_o,
  output logic [NSLOT-1:0][7:0] act_o
);
  logic [NSLOT-1:0][7:0] live_q, live_d, act_q, act_d;
  logic                  hit;
  logic [SLOT_W-1:0]     slot;

  assign {hit, slot} = slot_of(idx_i);

  always_comb begin
    live_d = live_q;
    if (wr_en_i && hit) live_d[slot] = wr_data_i;
    act_d = commit_i ? live_q : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
      act_q  <= '0;
    end else begin
      live_q <= live_d;
      act_q  <= act_d;
    end
  end

  assign rd_data_o = hit ? live_q[slot] : 8'h00;
  assign act_o     = act_q;

  // R5: the copy driving the datapath moves only on a STOP
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(act_q));
endmodule

// File: rtl/lmx_route.sv
module lmx_route
  import lmx_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [7:0]              mode_reg_i,
  input  logic [7:0]              gain_reg_i,
  input  logic [4*8-1:0]          eq_regs_i,
  input  logic [EQ_W-1:0]         strap_eq_i,
  input  logic [3:0]              strap_vod_i,
  output logic [LANES-1:0]        lane_en_o,
  output logic [LANES-1:0]        lane_dp_o,
  output logic                    flip_o,
  output logic [2*LANES*EQ_W-1:0] eq_code_o,
  output logic [3:0]              vod_gain_o,
  output logic [1:0]              role_o
);
  lane_mode_e mode;
  logic       flip;

  assign mode = lane_mode_e'(mode_reg_i[1:0]);
  assign flip = mode_reg_i[2];

  always_comb begin
    case (mode)
      MODE_USB: begin
        lane_en_o = flip ? 4'b1100 : 4'b0011;
        lane_dp_o = 4'b0000;
      end
      MODE_DP4: begin
        lane_en_o = 4'b1111;
        lane_dp_o = 4'b1111;
      end
      MODE_DP2_USB: begin
        lane_en_o = 4'b1111;
        lane_dp_o = flip ? 4'b0011 : 4'b1100;
      end
      default: begin
        lane_en_o = 4'b0000;
        lane_dp_o = 4'b0000;
      end
    endcase
  end

  genvar g;
  generate
    for (g = 0; g < 2*LANES; g++) begin : g_eq
      assign eq_code_o[g*EQ_W +: EQ_W] =
        mode_reg_i[4] ? eq_regs_i[g*EQ_W +: EQ_W] : strap_eq_i;
    end
  endgenerate

  assign flip_o     = flip;
  assign vod_gain_o = gain_reg_i[6] ? gain_reg_i[5:2] : strap_vod_i;
  assign role_o     = gain_reg_i[1:0];

  // R6: a lane never carries DP while disabled
  p_dp_within_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_dp_o & ~lane_en_o) == 4'b0000);
  // R7: lanes are always enabled as whole pairs, whichever way they are flipped
  p_pairs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_en_o[0] == lane_en_o[1]) && (lane_en_o[2] == lane_en_o[3]));
endmodule

// File: rtl/lmx_ctrl.sv
module lmx_ctrl
  import lmx_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR    = 7'h44,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe_o,
  input  logic [3:0]  strap_eq_i,
  input  logic [3:0]  strap_vod_i,
  output logic [3:0]  lane_en_o,
  output logic [3:0]  lane_dp_o,
  output logic        flip_o,
  output logic [31:0] eq_code_o,
  output logic [3:0]  vod_gain_o,
  output logic [1:0]  role_o
);
  logic                  wr_en, stop;
  logic [7:0]            idx, wr_data, rd_data;
  logic [NSLOT-1:0][7:0] act;

  lmx_i2c_tgt #(.TGT_ADDR(TGT_ADDR), .SYNC_STAGES(SYNC_STAGES)) u_bus (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_oe_o(sda_oe_o), .wr_en_o(wr_en), .idx_o(idx),
    .wr_data_o(wr_data), .rd_data_i(rd_data), .stop_o(stop)
  );

  lmx_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .idx_i(idx),
    .wr_data_i(wr_data), .commit_i(stop), .rd_data_o(rd_data), .act_o(act)
  );

  lmx_route u_route (
    .clk(clk), .rst_n(rst_n),
    .mode_reg_i(act[SL_MODE]), .gain_reg_i(act[SL_GAIN]),
    .eq_regs_i({act[SL_DN2], act[SL_DN1], act[SL_UP2], act[SL_UP1]}),
    .strap_eq_i(strap_eq_i), .strap_vod_i(strap_vod_i),
    .lane_en_o(lane_en_o), .lane_dp_o(lane_dp_o), .flip_o(flip_o),
    .eq_code_o(eq_code_o), .vod_gain_o(vod_gain_o), .role_o(role_o)
  );
endmodule

// File: tb/sim_lmx_ctrl.sv
`timescale 1ns/1ps
module sim_lmx_ctrl;
  localparam int H = 10;
  localparam int Q = 3;
  localparam logic [6:0] OWN = 7'h44;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic host_sda = 1'b1;
  logic sda_bus;
  logic sda_oe;
  logic [3:0] strap_eq = 4'h9;
  logic [3:0] strap_vod = 4'hA;
  logic [3:0] lane_en, lane_dp, vod_gain;
  logic flip;
  logic [31:0] eq_code;
  logic [1:0] role;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  assign sda_bus = host_sda & ~sda_oe;

  lmx_ctrl #(.TGT_ADDR(OWN)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .strap_eq_i(strap_eq), .strap_vod_i(strap_vod), .lane_en_o(lane_en),
    .lane_dp_o(lane_dp), .flip_o(flip), .eq_code_o(eq_code),
    .vod_gain_o(vod_gain), .role_o(role)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic [3:0] en, input logic [3:0] dp,
                         input logic fl, input logic [31:0] eq);
    chk({req, " lane_en"}, {28'd0, lane_en}, {28'd0, en});
    chk({req, " lane_dp"}, {28'd0, lane_dp}, {28'd0, dp});
    chk({req, " flip"}, {31'd0, flip}, {31'd0, fl});
    chk({req, " eq"}, eq_code, eq);
  endtask

  task automatic bus_start();
    host_sda = 1'b1; tick(Q);
    scl = 1'b1; tick(H);
    host_sda = 1'b0; tick(H);
    scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; tick(H - Q);
    scl = 1'b1; tick(H);
    host_sda = 1'b1; tick(H);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      host_sda = b[i]; tick(H - Q);
      scl = 1'b1; tick(H);
      scl = 1'b0; tick(Q);
    end
    host_sda = 1'b1; tick(H - Q);
    scl = 1'b1; tick(H / 2);
    ack = ~sda_bus; tick(H / 2);
    scl = 1'b0; tick(Q);
  endtask

  task automatic rbyte(input logic nack, output logic [7:0] d);
    host_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(H - Q);
      scl = 1'b1; tick(H / 2);
      d = {d[6:0], sda_bus}; tick(H / 2);
      scl = 1'b0; tick(Q);
    end
    host_sda = nack; tick(H - Q);
    scl = 1'b1; tick(H);
    scl = 1'b0; tick(Q);
  endtask

  // write n (1..2) data bytes from idx; optional STOP
  task automatic wr(input logic [7:0] idx, input int n, input logic [7:0] d0,
                    input logic [7:0] d1, input bit stop);
    logic ack;
    bus_start();
    wbyte({OWN, 1'b0}, ack); chk("R1 own address acked", {31'd0, ack}, 32'd1);
    wbyte(idx, ack);
    wbyte(d0, ack);
    if (n > 1) wbyte(d1, ack);
    if (stop) bus_stop();
  endtask

  task automatic rd(input logic [7:0] idx, input int n, output logic [7:0] r0,
                    output logic [7:0] r1, output logic [7:0] r2);
    logic ack;
    bus_start();
    wbyte({OWN, 1'b0}, ack);
    wbyte(idx, ack);
    bus_start();
    wbyte({OWN, 1'b1}, ack); chk("R3 read address acked", {31'd0, ack}, 32'd1);
    r1 = 8'h00; r2 = 8'h00;
    rbyte(n == 1, r0);
    if (n > 1) rbyte(n == 2, r1);
    if (n > 2) rbyte(1'b1, r2);
    bus_stop();
  endtask

  task automatic t_reset();
    chk_out("R4 reset", 4'b0000, 4'b0000, 1'b0, 32'h99999999);
    chk("R4 reset vod", {28'd0, vod_gain}, 32'hA);
    chk("R4 reset role", {30'd0, role}, 32'd0);
    chk("R4 reset sda released", {31'd0, sda_oe}, 32'd0);
  endtask

  task automatic t_usb_attach();
    wr(8'h0C, 1, 8'h58, 8'h00, 1'b1);
    chk("R9 vod from register", {28'd0, vod_gain}, 32'h6);
    chk("R9 role source", {30'd0, role}, 32'd0);
    wr(8'h10, 2, 8'h66, 8'h66, 1'b1);
    wr(8'h20, 2, 8'h33, 8'h34, 1'b1);
    chk("R8 override off eq from straps", eq_code, 32'h99999999);
    wr(8'h0A, 1, 8'h11, 8'h00, 1'b1);
    chk_out("R6 usb unflipped R2 autoinc", 4'b0011, 4'b0000, 1'b0, 32'h34336666);
  endtask

  task automatic t_atomic();
    wr(8'h0A, 1, 8'h1B, 8'h00, 1'b0);
    tick(2 * H);
    chk_out("R5 before stop", 4'b0011, 4'b0000, 1'b0, 32'h34336666);
    bus_stop();
    chk_out("R5 after stop R6 dp2+usb", 4'b1111, 4'b1100, 1'b0, 32'h34336666);
  endtask

  task automatic t_flip_modes();
    wr(8'h0A, 1, 8'h1F, 8'h00, 1'b1);
    chk_out("R7 dp2+usb flipped", 4'b1111, 4'b0011, 1'b1, 32'h34336666);
    wr(8'h0A, 1, 8'h15, 8'h00, 1'b1);
    chk_out("R7 usb flipped", 4'b1100, 4'b0000, 1'b1, 32'h34336666);
    wr(8'h0A, 1, 8'h1A, 8'h00, 1'b1);
    chk_out("R6 dp4", 4'b1111, 4'b1111, 1'b0, 32'h34336666);
    wr(8'h0A, 1, 8'h1E, 8'h00, 1'b1);
    chk_out("R7 dp4 flipped", 4'b1111, 4'b1111, 1'b1, 32'h34336666);
    wr(8'h0A, 1, 8'h10, 8'h00, 1'b1);
    chk_out("R6 off", 4'b0000, 4'b0000, 1'b0, 32'h34336666);
  endtask

  task automatic t_overrides();
    wr(8'h0A, 1, 8'h03, 8'h00, 1'b1);
    chk_out("R8 override cleared", 4'b1111, 4'b1100, 1'b0, 32'h99999999);
    wr(8'h0C, 1, 8'h1B, 8'h00, 1'b1);
    chk("R9 vod from straps", {28'd0, vod_gain}, 32'hA);
    chk("R9 role sink custom", {30'd0, role}, 32'd3);
  endtask

  task automatic t_foreign();
    logic ack;
    logic [7:0] a, b, c;
    bus_start();
    wbyte({7'h45, 1'b0}, ack); chk("R1 foreign not acked", {31'd0, ack}, 32'd0);
    wbyte(8'h0A, ack);
    wbyte(8'h11, ack);
    bus_stop();
    chk_out("R1 foreign no effect", 4'b1111, 4'b1100, 1'b0, 32'h99999999);
    rd(8'h0A, 1, a, b, c);
    chk("R1 register kept", {24'd0, a}, 32'h03);
  endtask

  task automatic t_read();
    logic [7:0] a, b, c;
    rd(8'h0A, 3, a, b, c);
    chk("R3 read 0x0A", {24'd0, a}, 32'h03);
    chk("R3 unimplemented 0x0B", {24'd0, b}, 32'h00);
    chk("R3 autoinc 0x0C", {24'd0, c}, 32'h1B);
    rd(8'h10, 2, a, b, c);
    chk("R3 read 0x10", {24'd0, a}, 32'h66);
    chk("R3 read 0x11", {24'd0, b}, 32'h66);
    rd(8'h21, 1, a, b, c);
    chk("R3 read 0x21", {24'd0, a}, 32'h34);
  endtask

  task automatic t_unimpl_write();
    logic [7:0] a, b, c;
    wr(8'h0B, 2, 8'h5A, 8'h7E, 1'b1);
    rd(8'h0B, 2, a, b, c);
    chk("R3 unimplemented ignores write", {24'd0, a}, 32'h00);
    chk("R2 index advanced past 0x0B", {24'd0, b}, 32'h7E);
    chk("R9 vod field 5:2", {28'd0, vod_gain}, 32'hF);
    chk("R9 role field 1:0", {30'd0, role}, 32'd2);
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_usb_attach();
    t_atomic();
    t_flip_modes();
    t_overrides();
    t_foreign();
    t_read();
    t_unimpl_write();
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule